// File: doc/BRIEF.md
# Serial Flash Fast-Read Responder

This block is the device-side half of a serial flash that answers a single command: the fast read. It runs on a local system clock and oversamples the serial clock, chip-select and serial data-in pins. When chip-select goes low, it collects an 8-bit instruction, a 24-bit start address and one dummy byte. Each of these bits is captured on a rising serial-clock edge. After that it streams bytes from an internal read-only array on the data-out pin, most significant bit first. Each data bit changes on a falling serial-clock edge.

After every byte the read address steps up by one. Past the top of the array it returns to location zero, so a single command can read the array any number of times. The next byte is fetched from the array's synchronous read port while the last bit of the current byte is on the wire, so the stream has no gaps. A busy input tells the block that an erase, program or write cycle is running. A fast read that starts while busy is high produces no data. Any opcode other than the fast read makes the block idle until chip-select returns high.

Top module: `fr_fastread_responder`

## Requirements
- R1: While reset is held and after it is released, `spi_miso_oe` is low and `spi_miso` is 0.
- R2: `spi_miso_oe` stays low while chip-select is high and through the whole instruction, address and dummy phase, which is 40 rising edges.
- R3: The fast-read opcode is 0x0B. The instruction, then the address and then the dummy byte are each taken MSB first, one bit per rising `spi_sck` edge. The first data bit is driven after the falling edge that follows the 40th rising edge.
- R4: Each data byte leaves MSB first. `spi_miso` changes only after a falling `spi_sck` edge and holds through the following rising edge.
- R5: The read address goes up by one after each complete byte, with no idle bit between bytes.
- R6: The byte after the highest location (2^MEM_AW - 1) is read from location 0.
- R7: Only the low MEM_AW address bits select a location. All higher bits, including bit 23, have no effect on the data.
- R8: Chip-select going high at any point, including inside a byte, ends the command and drops `spi_miso_oe` within a few system clocks. The next command then decodes from its first bit.
- R9: If `busy` is high when the eighth instruction bit is captured, the command is rejected and `spi_miso_oe` stays low until chip-select rises.
- R10: An opcode other than 0x0B causes every later bit to be ignored until chip-select rises, and no data is driven.
- R11: Array location a holds the byte (a*29 + 0x5A) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip-select from the host |
| spi_mosi | input | 1 | Serial data from host to device |
| busy | input | 1 | High while an erase, program or write cycle is in progress |
| spi_miso | output | 1 | Serial data from device to host, valid when `spi_miso_oe` is high |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; low means the pin is high impedance |

## Verification
The bench builds the block with MEM_AW set to 6, which gives a 64-byte array. With that size, a four-byte read starting at location 0x3E crosses the top and returns to 0. It also lets large 24-bit start addresses such as 0xFFFF85 and 0x800010 show that every bit above bit 5, including bit 23, is dropped. The serial clock runs at one tenth of the system clock, which leaves room for the two-stage synchronizer and the edge detector ahead of each sampled bit.

// File: rtl/fr_pkg.sv
// Shared definitions for the fast-read responder: controller states,
// the accepted opcode and the fixed array content pattern.
package fr_pkg;

    // Command controller phases.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_IGNORE
    } fr_state_e;

    localparam logic [7:0] FR_OPCODE = 8'h0B;

    // Content of array location loc.
    function automatic logic [7:0] fr_pattern(input int unsigned loc);
        int unsigned v;
        v = (loc * 29 + 90) % 256;
        return v[7:0];
    endfunction

endpackage

// File: rtl/fr_pin_sync.sv
// Multi-stage synchronizer for a group of asynchronous pins.
// Assumes each pin is held steady for several system clocks between changes.
module fr_pin_sync #(
    parameter int            W       = 3,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= RST_VAL;
        else        pipe[0] <= d;
    end

    // Remaining stages settle metastability.
    for (genvar gs = 1; gs < STAGES; gs++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[gs] <= RST_VAL;
            else        pipe[gs] <= pipe[gs-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/fr_rom_array.sv
// Read-only byte array with a registered read port. Contents are computed
// from fr_pattern. Assumes rd_addr is stable in the cycle rd_en is high.
module fr_rom_array
    import fr_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0] rom [DEPTH];

    for (genvar ga = 0; ga < DEPTH; ga++) begin : g_loc
        assign rom[ga] = fr_pattern(ga);
    end

    // Register the addressed byte when a fetch is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rom[rd_addr];
    end

endmodule

// File: rtl/fr_cmd_ctrl.sv
// Command decoder: counts rising serial-clock edges through the opcode,
// address and dummy phases, then runs the address during data output.
// Assumes edge pulses come from synchronized pins and last one system clock.
module fr_cmd_ctrl
    import fr_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              mosi_s,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              busy,
    input  logic              byte_done,
    output fr_state_e         state,
    output logic              shift_en,
    output logic              rd_en,
    output logic [MEM_AW-1:0] rd_addr
);

    localparam int SIN_W = (MEM_AW > 8) ? MEM_AW : 8;

    logic [4:0]       cnt;
    logic [SIN_W-2:0] sin;
    logic [SIN_W-1:0] sin_next;
    logic             opc_ok;

    assign sin_next = {sin, mosi_s};
    assign opc_ok   = (sin_next[7:0] == FR_OPCODE) && !busy;
    assign shift_en = (state == ST_DATA) && sck_fall && !cs_s;

    // Phase sequencing, bit capture and address stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            sin     <= '0;
            rd_addr <= '0;
            rd_en   <= 1'b0;
        end else begin
            rd_en <= 1'b0;
            if (cs_s) begin
                state <= ST_IDLE;
                cnt   <= '0;
            end else begin
                case (state)
                    ST_IDLE, ST_OPC: begin
                        state <= ST_OPC;
                        if (sck_rise) begin
                            sin <= sin_next[SIN_W-2:0];
                            if (cnt == 5'd7) begin
                                cnt   <= '0;
                                state <= opc_ok ? ST_ADDR : ST_IGNORE;
                            end else begin
                                cnt <= cnt + 5'd1;
                            end
                        end
                    end
                    ST_ADDR: begin
                        if (sck_rise) begin
                            sin <= sin_next[SIN_W-2:0];
                            if (cnt == 5'd23) begin
                                cnt     <= '0;
                                rd_addr <= sin_next[MEM_AW-1:0];
                                rd_en   <= 1'b1;
                                state   <= ST_DUMMY;
                            end else begin
                                cnt <= cnt + 5'd1;
                            end
                        end
                    end
                    ST_DUMMY: begin
                        if (sck_rise) begin
                            if (cnt == 5'd7) begin
                                cnt   <= '0;
                                state <= ST_DATA;
                            end else begin
                                cnt <= cnt + 5'd1;
                            end
                        end
                    end
                    ST_DATA: begin
                        if (byte_done) begin
                            rd_addr <= rd_addr + 1'b1;
                            rd_en   <= 1'b1;
                        end
                    end
                    default: begin
                        state <= ST_IGNORE;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/fr_out_shift.sv
// Output shifter: loads a byte from the read port on the first falling edge
// of each byte and shifts it out MSB first. Assumes rd_data is valid by then.
module fr_out_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_s,
    input  logic       shift_en,
    input  logic [7:0] rd_data,
    output logic       miso,
    output logic       oe,
    output logic       byte_done
);

    logic [2:0] bitpos;
    logic [7:0] sh;

    assign byte_done = shift_en && (bitpos == 3'd7);

    // Drive one bit per falling edge; release the pin when deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miso   <= 1'b0;
            oe     <= 1'b0;
            bitpos <= '0;
            sh     <= '0;
        end else if (cs_s) begin
            miso   <= 1'b0;
            oe     <= 1'b0;
            bitpos <= '0;
        end else if (shift_en) begin
            oe     <= 1'b1;
            bitpos <= bitpos + 3'd1;
            if (bitpos == 3'd0) begin
                miso <= rd_data[7];
                sh   <= {rd_data[6:0], 1'b0};
            end else begin
                miso <= sh[7];
                sh   <= {sh[6:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/fr_fastread_responder.sv
// Top level of the fast-read responder. Synchronizes the serial pins to clk,
// detects serial-clock edges and connects decoder, array and output shifter.
// Assumes the serial clock runs at most one eighth of clk.
module fr_fastread_responder
    import fr_pkg::*;
#(
    parameter int MEM_AW      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    input  logic busy,
    output logic spi_miso,
    output logic spi_miso_oe
);

    logic [2:0]        pins_s;
    logic              sck_s, cs_s, mosi_s, sck_d;
    logic              sck_rise, sck_fall;
    logic              shift_en, byte_done, rd_en;
    logic [MEM_AW-1:0] rd_addr;
    logic [7:0]        rd_data;
    fr_state_e         ctl_state;

    fr_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_sck, spi_cs_n, spi_mosi}),
        .q(pins_s)
    );

    assign sck_s  = pins_s[2];
    assign cs_s   = pins_s[1];
    assign mosi_s = pins_s[0];

    // Previous synchronized serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;

    fr_cmd_ctrl #(.MEM_AW(MEM_AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .mosi_s(mosi_s),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .busy(busy),
        .byte_done(byte_done), .state(ctl_state), .shift_en(shift_en),
        .rd_en(rd_en), .rd_addr(rd_addr)
    );

    fr_rom_array #(.MEM_AW(MEM_AW)) u_rom (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    fr_out_shift u_out (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .shift_en(shift_en),
        .rd_data(rd_data), .miso(spi_miso), .oe(spi_miso_oe),
        .byte_done(byte_done)
    );

endmodule

// File: rtl/fr_fastread_checker.sv
// Protocol checks for the fast-read responder, bound to the top module.
module fr_fastread_checker
    import fr_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs_s,
    input logic      shift_en,
    input logic      oe,
    input logic      miso,
    input fr_state_e state
);

    // R2: the pin is enabled only in the data phase
    a_r2_oe_only_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (state == ST_DATA));

    // R8: deselect releases the pin on the next clock
    a_r8_deselect_releases: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !oe);

    // R4: the data bit holds between falling edges
    a_r4_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && $past(oe) && !$past(shift_en)) |-> $stable(miso));

    // R3: output turns on only as the result of a falling edge in the data phase
    a_r3_enable_from_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(shift_en));

    // R9, R10: a rejected or unknown command keeps the pin released
    a_r10_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !oe);

    // R1: released during reset
    always_ff @(posedge clk) begin
        if (!rst_n) a_r1_reset_quiet: assert (!oe || $past(rst_n));
    end

endmodule

bind fr_fastread_responder fr_fastread_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .shift_en(shift_en),
    .oe(spi_miso_oe), .miso(spi_miso), .state(ctl_state)
);

// File: tb/fr_fastread_responder_test.sv
// Scoreboard bench: the driver queues expected bytes, the monitor assembles
// bytes on rising serial-clock edges and compares them.
module fr_fastread_responder_test;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam int H     = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic busy = 1'b0;
    wire  spi_miso, spi_miso_oe;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    bit   mon_active = 1'b0;
    bit   oe_seen = 1'b0;
    string mon_req = "";
    logic [7:0] exp_q [$];

    always #2.5 clk = ~clk;

    fr_fastread_responder #(.MEM_AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .busy(busy), .spi_miso(spi_miso),
        .spi_miso_oe(spi_miso_oe)
    );

    function automatic logic [7:0] exp_byte(input int a);
        int m;
        m = a % DEPTH;
        return 8'((m * 29 + 90) % 256);
    endfunction

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    always @(posedge clk) if (spi_miso_oe) oe_seen = 1'b1;

    // Monitor: gather data bits on rising edges, compare whole bytes.
    int         mbits = 0;
    logic [7:0] macc  = '0;
    always @(posedge spi_sck) begin
        if (!mon_active) begin
            mbits = 0;
        end else begin
            check(spi_miso_oe === 1'b1, {mon_req, " oe during data"}, int'(spi_miso_oe), 1);
            macc  = {macc[6:0], spi_miso};
            mbits = mbits + 1;
            if (mbits == 8) begin
                mbits = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, {mon_req, " unexpected byte"}, int'(macc), 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(macc === e, mon_req, int'(macc), int'(e));
                end
            end
        end
    end

    task automatic sck_cycle(input logic b);
        spi_mosi = b;
        repeat (H) @(negedge clk);
        spi_sck = 1'b1;
        repeat (H) @(negedge clk);
        spi_sck = 1'b0;
    endtask

    // Driver: one command with nbytes full bytes plus extra data bits.
    task automatic run_cmd(input logic [7:0] op, input logic [23:0] a, input int nbytes,
                           input int extra, input bit expect_data, input string req);
        if (expect_data)
            for (int i = 0; i < nbytes; i++) exp_q.push_back(exp_byte(int'(a) + i));
        @(negedge clk);
        oe_seen  = 1'b0;
        spi_cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 7; i >= 0; i--)  sck_cycle(op[i]);
        for (int i = 23; i >= 0; i--) sck_cycle(a[i]);
        for (int i = 0; i < 8; i++)   sck_cycle(1'b1);
        check(oe_seen == 1'b0, "R2 header quiet", int'(oe_seen), 0);
        mon_req    = req;
        mon_active = expect_data;
        for (int i = 0; i < nbytes * 8 + extra; i++) sck_cycle(1'b0);
        mon_active = 1'b0;
        repeat (H) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (6) @(negedge clk);
        check(spi_miso_oe == 1'b0, "R8 released after deselect", int'(spi_miso_oe), 0);
        if (expect_data)
            check(exp_q.size() == 0, {req, " bytes missing"}, exp_q.size(), 0);
        else
            check(oe_seen == 1'b0, {req, " no data driven"}, int'(oe_seen), 0);
        exp_q.delete();
        repeat (3 * H) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(spi_miso_oe == 1'b0 && spi_miso == 1'b0, "R1 reset", int'(spi_miso_oe), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(spi_miso_oe == 1'b0, "R1 after reset", int'(spi_miso_oe), 0);

        run_cmd(8'h0B, 24'h000003, 3, 0, 1'b1, "R3 R4 R5 R11 basic read");
        run_cmd(8'h0B, 24'h00003E, 4, 0, 1'b1, "R6 wrap to zero");
        run_cmd(8'h0B, 24'hFFFF85, 2, 0, 1'b1, "R7 upper bits ignored");
        run_cmd(8'h0B, 24'h800010, 2, 0, 1'b1, "R7 bit 23 ignored");
        busy = 1'b1;
        run_cmd(8'h0B, 24'h000000, 2, 0, 1'b0, "R9 busy rejects");
        busy = 1'b0;
        run_cmd(8'h03, 24'h000000, 2, 0, 1'b0, "R10 other opcode");
        run_cmd(8'h0B, 24'h000020, 1, 3, 1'b1, "R8 abort mid byte");
        run_cmd(8'h0B, 24'h000021, 2, 0, 1'b1, "R8 fresh command after abort");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule